// File: doc/BRIEF.md
# TMDS Character Boundary Synchronizer

This block sits behind the deserializer of one serial video lane. Each pixel clock it receives a 10-bit word. The word is correct at the bit level, but its boundary may fall anywhere inside a transmitted character. The block places the previous word and the current word side by side. Across that 20-bit span it tests all ten possible starting bits for a control character.

A control-like pattern can appear by chance across the seam between two symbols, so a single match proves nothing. Each starting bit therefore keeps its own count of consecutive matches. The block commits to a starting bit only when that count reaches a parameterised run length. From then on it emits re-aligned characters and holds a synchronized flag.

Once locked, the block keeps the chosen offset through active video. It moves to a new offset only when a later blanking interval shows an unbroken run at that new offset.

Top module: `tmds_char_sync`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `sync_out`, `offset_out`, `char_out`, the stored previous word and every run counter to zero. The reset is synchronous and active high.
- R2: The candidate character at offset k (0..9) is bits k+9 down to k of the concatenation {current `raw_in`, previous `raw_in``}. Bit 0 of a word is the earliest bit on the wire. A lane whose character boundaries fall p bits into each word therefore locks at offset p mod 10.
- R3: A candidate counts as a control character only if it equals one of the four values 10'b1101010100, 10'b0010101011, 10'b0101010100 and 10'b1010101011. Other alternating patterns such as 10'b0101010101 never count.
- R4: A run counter per offset counts consecutive cycles with a control character at that offset. The counter saturates at LOCK_RUN. In the clock edge where an offset sees its LOCK_RUN-th consecutive control character, `sync_out` goes to 1 and `offset_out` takes that offset. If several offsets complete a run in the same cycle, the lowest offset wins.
- R5: A run shorter than LOCK_RUN, or a run broken by any non-control candidate, does not lock.
- R6: Once `sync_out` is 1 it stays 1 until reset. `offset_out` holds through any amount of non-control data.
- R7: While locked, an offset different from the latched one that completes a run replaces it. This happens in the same edge where that run completes, unless the latched offset also has an unbroken run of at least LOCK_RUN in that cycle.
- R8: `char_out` is registered. After each edge it equals the candidate, in the cycle before that edge, at the offset latched before that edge.
- R9: With the default LOCK_RUN of 16, a blanking interval longer than 128 characters always ends with `sync_out` set and the lane's true offset latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_in | input | 10 | Deserialized word with unknown character boundary |
| char_out | output | 10 | Re-aligned character, one cycle of latency |
| sync_out | output | 1 | Boundary lock established |
| offset_out | output | 4 | Latched bit offset (0..9) into the 20-bit span |

## Verification
Some properties are checked on every cycle:
- the offset stays in range;
- the flag never drops once set;
- a lock or a move of the offset always coincides with a completed run;
- the latched offset never moves while its own run is unbroken at full length;
- no counter passes the threshold, and none counts without a match in the previous cycle.

The bench scenarios cover what those properties cannot:
- the exact edge at which lock lands;
- the rejection of short, broken and look-alike runs;
- relock after a bit slip;
- locking within a long blanking interval.

For these, a behavioural model built on a serialized bit queue is compared against all three outputs on every clock.

// File: rtl/tmds_align_pkg.sv
package tmds_align_pkg;

    localparam int CHAR_W = 10;
    localparam int WIN_W  = 2 * CHAR_W;
    localparam int N_OFF  = CHAR_W;
    localparam int OFF_W  = $clog2(N_OFF);

    typedef logic [CHAR_W-1:0] char_t;
    typedef logic [WIN_W-1:0]  win_t;
    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [N_OFF-1:0]  offvec_t;

    // Lock state carried between the decision logic and the output stage
    typedef struct packed {
        logic sync;
        off_t off;
    } lock_t;

    localparam char_t CTL_A = 10'b1101010100;
    localparam char_t CTL_B = 10'b0010101011;
    localparam char_t CTL_C = 10'b0101010100;
    localparam char_t CTL_D = 10'b1010101011;

    function automatic logic is_ctrl(input char_t c);
        return (c == CTL_A) || (c == CTL_B) || (c == CTL_C) || (c == CTL_D);
    endfunction

    // Lowest set index wins
    function automatic off_t lowest_set(input offvec_t v);
        off_t r;
        r = '0;
        for (int i = N_OFF - 1; i >= 0; i--) begin
            if (v[i]) r = off_t'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/tmds_ctrl_scan.sv
module tmds_ctrl_scan
    import tmds_align_pkg::*;
(
    input  win_t    win,
    output offvec_t hit
);

    for (genvar k = 0; k < N_OFF; k++) begin : g_tap
        assign hit[k] = is_ctrl(win[k +: CHAR_W]);
    end

endmodule

// File: rtl/tmds_run_bank.sv
module tmds_run_bank
    import tmds_align_pkg::*;
#(
    parameter int LOCK_RUN = 16
) (
    input  logic    clk,
    input  logic    rst,
    input  offvec_t hit,
    output offvec_t reached,
    output offvec_t full
);

    localparam int CNT_W = $clog2(LOCK_RUN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(LOCK_RUN);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_RUN - 1);

    logic [CNT_W-1:0] cnt [N_OFF];

    for (genvar k = 0; k < N_OFF; k++) begin : g_run
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt[k] <= '0;
            end else if (!hit[k]) begin
                cnt[k] <= '0;
            end else if (cnt[k] < CNT_MAX) begin
                cnt[k] <= cnt[k] + 1'b1;
            end
        end

        assign reached[k] = hit[k] && (cnt[k] == CNT_LAST);
        assign full[k]    = hit[k] && (cnt[k] >= CNT_LAST);

        p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
            cnt[k] <= CNT_MAX);

        p_cnt_needs_hit_r5: assert property (@(posedge clk) disable iff (rst)
            (cnt[k] != '0) |-> $past(hit[k]));
    end

endmodule

// File: rtl/tmds_lock_fsm.sv
module tmds_lock_fsm
    import tmds_align_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  offvec_t reached,
    input  offvec_t full,
    output lock_t   lk
);

    lock_t lk_nxt;
    logic  keep_cur;

    always_comb begin
        keep_cur = lk.sync && full[lk.off];
        lk_nxt   = lk;
        if ((reached != '0) && !keep_cur) begin
            lk_nxt.sync = 1'b1;
            lk_nxt.off  = lowest_set(reached);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) lk <= '0;
        else     lk <= lk_nxt;
    end

    p_sync_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        lk.sync |=> lk.sync);

    p_move_needs_run_r7: assert property (@(posedge clk) disable iff (rst)
        (lk.off != $past(lk.off)) |-> ($past(reached) != '0));

    p_hold_full_r7: assert property (@(posedge clk) disable iff (rst)
        (lk.sync && full[lk.off]) |=> $stable(lk.off));

endmodule

// File: rtl/tmds_char_sync.sv
module tmds_char_sync
    import tmds_align_pkg::*;
#(
    parameter int LOCK_RUN = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CHAR_W-1:0] raw_in,
    output logic [CHAR_W-1:0] char_out,
    output logic              sync_out,
    output logic [OFF_W-1:0]  offset_out
);

    char_t   raw_q;
    win_t    win;
    offvec_t hit;
    offvec_t reached;
    offvec_t full;
    lock_t   lk;
    char_t   char_q;

    always_ff @(posedge clk) begin
        if (rst) raw_q <= '0;
        else     raw_q <= raw_in;
    end

    assign win = {raw_in, raw_q};

    tmds_ctrl_scan u_scan (
        .win (win),
        .hit (hit)
    );

    tmds_run_bank #(.LOCK_RUN(LOCK_RUN)) u_runs (
        .clk     (clk),
        .rst     (rst),
        .hit     (hit),
        .reached (reached),
        .full    (full)
    );

    tmds_lock_fsm u_lock (
        .clk     (clk),
        .rst     (rst),
        .reached (reached),
        .full    (full),
        .lk      (lk)
    );

    always_ff @(posedge clk) begin
        if (rst) char_q <= '0;
        else     char_q <= win[lk.off +: CHAR_W];
    end

    assign char_out   = char_q;
    assign sync_out   = lk.sync;
    assign offset_out = lk.off;

    p_off_range_r2: assert property (@(posedge clk) disable iff (rst)
        offset_out < OFF_W'(N_OFF));

    p_lock_on_ctrl_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_out) |-> ((($past(hit) >> offset_out) & offvec_t'(1)) != '0));

endmodule

// File: tb/tmds_char_sync_bench.sv
module tmds_char_sync_bench;
    localparam int CLK_PERIOD = 10;
    localparam int RUN = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] raw_in = '0;
    logic [9:0] char_out;
    logic       sync_out;
    logic [3:0] offset_out;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tmds_char_sync #(.LOCK_RUN(RUN)) u_tmds_char_sync (
        .clk(clk), .rst(rst), .raw_in(raw_in),
        .char_out(char_out), .sync_out(sync_out), .offset_out(offset_out)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    // behavioural reference state
    int         m_cnt [10];
    bit         m_sync;
    int         m_off;
    logic [9:0] m_prev;
    logic [9:0] m_char;

    bit bq[$];
    int pad_total = 0;

    localparam logic [9:0] CODES [4] = '{10'b1101010100, 10'b0010101011,
                                         10'b0101010100, 10'b1010101011};

    function automatic bit m_is_ctrl(logic [9:0] c);
        foreach (CODES[i]) if (c == CODES[i]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    task automatic cyc(logic [9:0] w, bit r);
        logic [19:0] win;
        logic [9:0]  nchar;
        int          nc [10];
        bit          fullv [10];
        int          cand;
        bit          nsync;
        int          noff;
        raw_in = w;
        rst    = r;
        win    = {w, m_prev};
        cand   = -1;
        nsync  = m_sync;
        noff   = m_off;
        nchar  = 10'(win >> m_off);
        for (int k = 0; k < 10; k++) begin
            bit h;
            h = m_is_ctrl(10'(win >> k));
            nc[k]    = h ? ((m_cnt[k] + 1 > RUN) ? RUN : m_cnt[k] + 1) : 0;
            fullv[k] = h && (m_cnt[k] >= RUN - 1);
            if (h && m_cnt[k] == RUN - 1 && cand < 0) cand = k;
        end
        if (cand >= 0 && !(m_sync && fullv[m_off])) begin
            nsync = 1'b1;
            noff  = cand;
        end
        @(posedge clk);
        @(negedge clk);
        if (r) begin
            foreach (m_cnt[k]) m_cnt[k] = 0;
            m_sync = 0; m_off = 0; m_prev = '0; m_char = '0;
        end else begin
            foreach (m_cnt[k]) m_cnt[k] = nc[k];
            m_sync = nsync; m_off = noff; m_prev = w; m_char = nchar;
        end
        check(char_out == m_char, "R8", int'(char_out), int'(m_char));
        check(sync_out == m_sync, "R4", int'(sync_out), int'(m_sync));
        check(int'(offset_out) == m_off, "R7", int'(offset_out), m_off);
    endtask

    task automatic put_char(logic [9:0] c);
        logic [9:0] w;
        for (int i = 0; i < 10; i++) bq.push_back(c[i]);
        while (bq.size() >= 10) begin
            for (int i = 0; i < 10; i++) w[i] = bq.pop_front();
            cyc(w, 1'b0);
        end
    endtask

    task automatic pad(int n);
        repeat (n) bq.push_back(1'b0);
        pad_total += n;
    endtask

    task automatic blank(int n);
        for (int i = 0; i < n; i++) put_char(CODES[(i / 4) % 4]);
    endtask

    task automatic video(int n);
        logic [9:0] d;
        repeat (n) begin
            d = 10'($urandom());
            while (m_is_ctrl(d)) d = 10'($urandom());
            put_char(d);
        end
    endtask

    task automatic do_reset();
        cyc('0, 1'b1);
        cyc('0, 1'b1);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: everything cleared
        check(sync_out == 0 && offset_out == 0 && char_out == 0, "R1",
              int'(sync_out), 0);

        pad(3);
        video(40);
        check(sync_out == 0, "R5", int'(sync_out), 0);

        // R3: look-alike alternating pattern never counts
        repeat (30) put_char(10'b0101010101);
        check(sync_out == 0, "R3", int'(sync_out), 0);

        // R5: short and broken runs
        blank(15);
        put_char(10'b0011100101);
        blank(15);
        check(sync_out == 0, "R5", int'(sync_out), 0);
        video(5);

        blank(20);
        check(sync_out == 1, "R4", int'(sync_out), 1);
        check(int'(offset_out) == pad_total % 10, "R2", int'(offset_out), pad_total % 10);

        video(60);
        check(sync_out == 1 && int'(offset_out) == 3, "R6", int'(offset_out), 3);

        // R7: bit slip, then relock
        pad(4);
        blank(10);
        check(int'(offset_out) == 3, "R7", int'(offset_out), 3);
        blank(10);
        check(int'(offset_out) == pad_total % 10, "R7", int'(offset_out), pad_total % 10);

        video(30);
        pad(5);
        blank(129);
        check(int'(offset_out) == pad_total % 10, "R9", int'(offset_out), pad_total % 10);

        // fresh reset, then a long blanking interval
        do_reset();
        check(sync_out == 0 && offset_out == 0, "R1", int'(sync_out), 0);
        video(20);
        blank(129);
        check(sync_out == 1, "R9", int'(sync_out), 1);
        check(int'(offset_out) == pad_total % 10, "R9", int'(offset_out), pad_total % 10);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule